// File: doc/BRIEF.md
# Quasi-Random Line Test Pattern Generator

This block produces a serial test pattern for a T1 or E1 transmit path. In T1 mode it runs a 20-stage pseudo-random sequence, which has a period of 2^20-1 bits. A one is forced into the stream whenever a fifteenth consecutive zero would go out. In E1 mode it runs a 15-stage sequence, which has a period of 2^15-1 bits, and the output is inverted. The generator advances one bit on each cycle where the bit-clock enable is high. The pattern bit and a bipolar-violation marker are registered, and they go to the downstream line encoder.

Two request inputs come from outside the clock domain. A rising edge on the first one flips a single outgoing bit. That logic error is held back for one bit when it would land on a bit position that is forced to one. A rising edge on the second one flags a single bipolar violation for the encoder, whatever line-code mode the encoder uses. Both requests are synchronised and edge-detected, then held pending until the next bit enable. The generator runs only when the two-bit pattern select is binary 10. In any other case it is idle: both outputs are held low and the sequence is kept at its seed.

Top module: `qrss_gen`

## Requirements
- R1: The generator is active only when `pat_sel[1]`=1 and `pat_sel[0]`=0. In every other cycle, `pat_bit` and `bpv_flag` are 0 from the next clock edge on, and bit enables have no effect.
- R2: T1 mode (`e1_mode`=0) works as follows. The state S is 20 bits and starts at SEED_T1, which is 1 by default. Each bit enable sends S[19] and then shifts S left, with new S[0] = S[19] xor S[16]. The sent bit appears on `pat_bit` after the enabling clock edge.
- R3: In T1 mode, when the last 14 bits sent were all zero, the next bit sent is 1. No run of zeros on `pat_bit` exceeds 14. A bit forced to one counts as a one.
- R4: E1 mode (`e1_mode`=1) works as follows. The state is 15 bits and starts at SEED_E1, which is 1 by default. Each bit enable sends the inverse of S[14] and then shifts S left, with new S[0] = S[14] xor S[13]. No bit is forced to one in this mode.
- R5: A rising edge on `err_req` inverts exactly one sent bit: the first eligible bit enable after the request has passed the synchroniser. Holding `err_req` high or low adds no further errors.
- R6: In T1 mode, a pending error that falls on a forced-one position (14 zeros just sent) is not applied there. That bit goes out as 1 and the error inverts the following bit.
- R7: A rising edge on `bpv_req` sets `bpv_flag` for exactly one bit period. That period is the one beginning at the next bit enable. The pattern bit is unaffected.
- R8: While active, `pat_bit` and `bpv_flag` change only on clock edges where `bit_en` is high.
- R9: The sequence restarts from its seed whenever `e1_mode` changes or the generator leaves the idle state. The zero-run count restarts at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe that advances the pattern by one bit |
| pat_sel | input | 2 | Pattern select; binary 10 enables the generator |
| e1_mode | input | 1 | 0 = T1 sequence with zero-run cap, 1 = E1 sequence inverted |
| err_req | input | 1 | Asynchronous request; rising edge inserts one logic error |
| bpv_req | input | 1 | Asynchronous request; rising edge flags one bipolar violation |
| pat_bit | output | 1 | Serial pattern bit |
| bpv_flag | output | 1 | Bipolar-violation marker for the line encoder |

## Verification
Every sent bit goes straight to `pat_bit`. A wrong state or tap therefore shows within the first bits after seeding, and a wrong mode reload shows on the first bit after a mode switch. The default seed of 1 pushes a long zero run out of the T1 register at once. As a result, an off-by-one zero-run limit or a faulty error deferral appears within the first twenty bits. A stuck pending flag shows as a second inverted bit or a second violation marker on the following enables.

// File: rtl/qrss_pkg.sv
package qrss_pkg;

    localparam int T1_LEN   = 20;
    localparam int T1_TAP   = 17;
    localparam int E1_LEN   = 15;
    localparam int E1_TAP   = 14;
    localparam int ZRUN_CAP = 14;

    typedef enum logic {
        MODE_T1 = 1'b0,
        MODE_E1 = 1'b1
    } line_mode_e;

    typedef struct packed {
        logic value;
        logic forced;
    } tx_bit_t;

    function automatic logic [T1_LEN-1:0] lfsr_next(input logic [T1_LEN-1:0] s,
                                                    input line_mode_e m);
        logic [T1_LEN-1:0] n;
        n = '0;
        if (m == MODE_T1) begin
            n = {s[T1_LEN-2:0], s[T1_LEN-1] ^ s[T1_TAP-1]};
        end else begin
            n[E1_LEN-1:0] = {s[E1_LEN-2:0], s[E1_LEN-1] ^ s[E1_TAP-1]};
        end
        return n;
    endfunction

    function automatic logic lfsr_msb(input logic [T1_LEN-1:0] s, input line_mode_e m);
        return (m == MODE_T1) ? s[T1_LEN-1] : s[E1_LEN-1];
    endfunction

endpackage

// File: rtl/qrss_req_sync.sv
module qrss_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= req_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/qrss_lfsr.sv
module qrss_lfsr
    import qrss_pkg::*;
#(
    parameter logic [T1_LEN-1:0] SEED_T1 = 20'h00001,
    parameter logic [T1_LEN-1:0] SEED_E1 = 20'h00001
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       adv,
    input  line_mode_e mode,
    output logic       raw
);
    localparam logic [E1_LEN-1:0] E1_SEED_CUT = SEED_E1[E1_LEN-1:0];

    logic [T1_LEN-1:0] state_q;
    logic [T1_LEN-1:0] seed;

    always_comb begin
        seed = SEED_T1;
        if (mode == MODE_E1) begin
            seed = '0;
            seed[E1_LEN-1:0] = E1_SEED_CUT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) state_q <= seed;
        else if (adv)    state_q <= lfsr_next(state_q, mode);
    end

    assign raw = lfsr_msb(state_q, mode);
endmodule

// File: rtl/qrss_shaper.sv
module qrss_shaper
    import qrss_pkg::*;
#(
    parameter int ZMAX = ZRUN_CAP
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       restart,
    input  logic       step,
    input  line_mode_e mode,
    input  logic       raw,
    input  logic       err_rise,
    input  logic       bpv_rise,
    output logic       pat_bit,
    output logic       bpv_flag,
    output logic       err_pend
);
    localparam int ZW = $clog2(ZMAX + 1);
    localparam logic [ZW-1:0] ZTOP = ZW'(ZMAX);

    logic [ZW-1:0] zrun_q;
    logic          bpv_pend;
    logic          apply_err;
    tx_bit_t       nxt;

    always_comb begin
        nxt.forced = (mode == MODE_T1) && (zrun_q == ZTOP);
        apply_err  = err_pend && !nxt.forced;
        nxt.value  = nxt.forced ? 1'b1
                   : (raw ^ (mode == MODE_E1) ^ apply_err);
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pat_bit  <= 1'b0;
            bpv_flag <= 1'b0;
            err_pend <= 1'b0;
            bpv_pend <= 1'b0;
            zrun_q   <= '0;
        end else if (restart) begin
            zrun_q   <= '0;
            err_pend <= err_pend | err_rise;
            bpv_pend <= bpv_pend | bpv_rise;
        end else if (step) begin
            pat_bit  <= nxt.value;
            bpv_flag <= bpv_pend;
            bpv_pend <= bpv_rise;
            err_pend <= (err_pend & ~apply_err) | err_rise;
            if (nxt.value)            zrun_q <= '0;
            else if (zrun_q != ZTOP)  zrun_q <= zrun_q + 1'b1;
        end else begin
            err_pend <= err_pend | err_rise;
            bpv_pend <= bpv_pend | bpv_rise;
        end
    end
endmodule

// File: rtl/qrss_gen.sv
module qrss_gen
    import qrss_pkg::*;
#(
    parameter logic [T1_LEN-1:0] SEED_T1     = 20'h00001,
    parameter logic [T1_LEN-1:0] SEED_E1     = 20'h00001,
    parameter int                SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic [1:0] pat_sel,
    input  logic       e1_mode,
    input  logic       err_req,
    input  logic       bpv_req,
    output logic       pat_bit,
    output logic       bpv_flag
);
    line_mode_e mode, mode_q;
    logic       active, active_q, restart, step, raw;
    logic       err_rise, bpv_rise, err_pend;

    assign mode    = e1_mode ? MODE_E1 : MODE_T1;
    assign active  = (pat_sel == 2'b10);
    assign restart = !active || !active_q || (mode != mode_q);
    assign step    = bit_en && active && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_T1;
            active_q <= 1'b0;
        end else begin
            mode_q   <= mode;
            active_q <= active;
        end
    end

    qrss_req_sync #(.STAGES(SYNC_STAGES)) u_err_sync (
        .clk(clk), .rst(rst), .req_in(err_req), .rise(err_rise));

    qrss_req_sync #(.STAGES(SYNC_STAGES)) u_bpv_sync (
        .clk(clk), .rst(rst), .req_in(bpv_req), .rise(bpv_rise));

    qrss_lfsr #(.SEED_T1(SEED_T1), .SEED_E1(SEED_E1)) u_lfsr (
        .clk(clk), .rst(rst), .load(restart), .adv(step), .mode(mode), .raw(raw));

    qrss_shaper #(.ZMAX(ZRUN_CAP)) u_shape (
        .clk(clk), .rst(rst), .active(active), .restart(restart), .step(step),
        .mode(mode), .raw(raw), .err_rise(err_rise), .bpv_rise(bpv_rise),
        .pat_bit(pat_bit), .bpv_flag(bpv_flag), .err_pend(err_pend));
endmodule

// File: rtl/qrss_gen_chk.sv
module qrss_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic [1:0] pat_sel,
    input logic       e1_mode,
    input logic       pat_bit,
    input logic       bpv_flag,
    input logic       err_rise,
    input logic       err_pend
);
    logic   act, step_d, e1_d;
    int     zc;

    assign act = (pat_sel == 2'b10);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_d <= 1'b0;
            e1_d   <= 1'b0;
            zc     <= 0;
        end else begin
            step_d <= bit_en && act;
            e1_d   <= e1_mode;
            if (!act || (e1_mode != e1_d)) zc <= 0;
            else if (step_d)               zc <= pat_bit ? 0 : (zc < 100 ? zc + 1 : zc);
        end
    end

    // R3: no zero run longer than the cap in T1 mode
    a_r3_zero_cap: assert property (@(posedge clk) disable iff (rst)
        (act && !e1_mode && (e1_mode == e1_d)) |-> (zc <= 14));

    // R1: idle select forces both outputs low
    a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
        !act |=> (!pat_bit && !bpv_flag));

    // R8: outputs only move on enable edges while active
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (act && !bit_en) |=> (!act || ($stable(pat_bit) && $stable(bpv_flag))));

    // R5: a detected request edge is held pending
    a_r5_pending: assert property (@(posedge clk) disable iff (rst)
        (act && err_rise) |=> (err_pend || !act));
endmodule

bind qrss_gen qrss_gen_chk u_chk (
    .clk(clk), .rst(rst), .bit_en(bit_en), .pat_sel(pat_sel), .e1_mode(e1_mode),
    .pat_bit(pat_bit), .bpv_flag(bpv_flag), .err_rise(err_rise), .err_pend(err_pend));

// File: tb/qrss_gen_tb.sv
module qrss_gen_tb_top;
    localparam time CLK_P = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic [1:0] pat_sel = 2'b00;
    logic       e1_mode = 1'b0;
    logic       err_req = 1'b0;
    logic       bpv_req = 1'b0;
    logic       pat_bit, bpv_flag;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [19:0] ms;
    int          mz;
    bit          mpe;
    int          maxz;
    int          zcur;

    always #(CLK_P/2) clk = ~clk;

    qrss_gen dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .pat_sel(pat_sel), .e1_mode(e1_mode),
        .err_req(err_req), .bpv_req(bpv_req), .pat_bit(pat_bit), .bpv_flag(bpv_flag));

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_seed();
        ms = 20'h00001;
        mz = 0;
    endtask

    function automatic logic model_bit();
        logic raw, forced, ae, b;
        raw    = e1_mode ? ~ms[14] : ms[19];
        forced = !e1_mode && (mz == 14);
        ae     = mpe && !forced;
        b      = forced ? 1'b1 : (raw ^ ae);
        if (ae) mpe = 1'b0;
        mz = b ? 0 : (mz < 14 ? mz + 1 : mz);
        if (e1_mode) ms = {5'b0, ms[13:0], ms[14] ^ ms[13]};
        else         ms = {ms[18:0], ms[19] ^ ms[16]};
        return b;
    endfunction

    task automatic step();
        @(negedge clk) bit_en = 1'b1;
        @(negedge clk) bit_en = 1'b0;
    endtask

    task automatic run(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            logic e;
            step();
            e = model_bit();
            check(req, pat_bit, e);
            zcur = pat_bit ? 0 : zcur + 1;
            if (zcur > maxz) maxz = zcur;
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        mpe = 1'b0; maxz = 0; zcur = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset pat_bit", pat_bit, 1'b0);
        check("R1 reset bpv_flag", bpv_flag, 1'b0);

        // R2/R3: T1 from seed 1 starts with a long zero run that must be capped
        pat_sel = 2'b10; e1_mode = 1'b0; settle(); model_seed();
        run("R2/R3 T1 sequence", 700);
        check("R3 max zero run <= 14", maxz <= 14, 1'b1);

        // R9 + R6: restart, send 14 zeros, then error lands on forced bit
        pat_sel = 2'b00; settle(); pat_sel = 2'b10; settle(); model_seed(); zcur = 0;
        run("R9 restart zeros", 14);
        @(negedge clk) err_req = 1'b1; repeat (4) @(negedge clk); mpe = 1'b1;
        step(); void'(model_bit());
        check("R6 forced bit stays one", pat_bit, 1'b1);
        run("R6 deferred error", 1);
        check("R6 error consumed", mpe, 1'b0);
        run("R5 held high adds nothing", 60);
        @(negedge clk) err_req = 1'b0; settle();
        run("R5 low adds nothing", 30);

        // R5: error mid-stream inverts exactly one bit
        @(negedge clk) err_req = 1'b1; repeat (4) @(negedge clk); mpe = 1'b1;
        run("R5 single error", 20);
        @(negedge clk) err_req = 1'b0; settle();

        // R7: violation marker for one bit, pattern untouched
        @(negedge clk) bpv_req = 1'b1; repeat (4) @(negedge clk);
        check("R7 no flag before enable", bpv_flag, 1'b0);
        run("R7 pattern unaffected", 1);
        check("R7 flag set", bpv_flag, 1'b1);
        // R8: outputs hold between enables
        for (int k = 0; k < 5; k++) begin
            logic hold_b;
            hold_b = pat_bit;
            @(negedge clk);
            check("R8 flag holds", bpv_flag, 1'b1);
            check("R8 bit holds", pat_bit, hold_b);
        end
        run("R7 next bit", 1);
        check("R7 flag one period", bpv_flag, 1'b0);
        @(negedge clk) bpv_req = 1'b0; settle();

        // R4/R9: E1 mode reloads and runs inverted
        e1_mode = 1'b1; settle(); model_seed();
        run("R4/R9 E1 sequence", 500);
        @(negedge clk) err_req = 1'b1; repeat (4) @(negedge clk); mpe = 1'b1;
        run("R5 E1 error", 20);
        @(negedge clk) err_req = 1'b0; settle();

        // R9: back to T1 restarts from seed
        e1_mode = 1'b0; settle(); model_seed(); zcur = 0; maxz = 0;
        run("R9 T1 after E1", 100);

        // R1: other select codes idle
        for (int s = 0; s < 4; s++) begin
            if (s == 2) continue;
            pat_sel = 2'(s); settle();
            step();
            check("R1 idle pat_bit", pat_bit, 1'b0);
            check("R1 idle bpv_flag", bpv_flag, 1'b0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule